// File: doc/BRIEF.md
# DSP control register file

This block holds the control registers of a DSP core: the addressing mode, the control and status word, the interrupt enable and flag registers, the interrupt and nonmaskable return pointers, the service table pointer and three floating-point configuration words. One execution unit reaches the block through a single 5-bit register address. It has one write port, which takes effect at the next clock edge, and one combinational read port.

Some addresses decode differently for reads and for writes. A write to the flag address sets flag bits, a write to the clear address clears them, and the clear address reads as zero. The execution-phase program counter can be read but not written.

The block also applies the hardware side paths. External interrupt pins raise flags. Taking an interrupt clears its flag and saves the global enable. A return event restores the global enable. A saturating result sets a sticky status bit. The register values are presented on outputs for the rest of the core.

Top module: `ctl_regbank`

## Requirements
- R1: The registers at addresses 00000 (mode), 00001 (status), 00100 (enable), 00101 (table pointer), 00110 (return pointer), 00111 (nonmaskable return pointer), 10010, 10011 and 10100 (floating-point configuration) read back their contents. A write to any of them updates the register at the next clock edge.
- R2: Reading address 00010 returns the interrupt flags, with bit m for pin m and the bits at NUM_IRQ and above at zero. A write to 00010 sets every flag whose data bit is 1, and data bits at 0 leave their flags unchanged.
- R3: A write to 00011 clears every flag whose data bit is 1, and data bits at 0 leave their flags unchanged. Reading 00011 always returns zero.
- R4: Reading 10000 returns pc_e1_i in the same cycle, and a write to 10000 changes no register.
- R5: Any address not listed in R1 to R4 reads as zero, and a write to it changes no register.
- R6: irq_pin_i[m] high at a clock edge sets flag m.
- R7: When a pin and a software clear or an interrupt-entry clear hit the same flag in one cycle, the flag ends set.
- R8: irq_take_i clears flag irq_take_id_i, copies status bit 0 (global enable) into status bit 1 (saved enable) and clears bit 0, all at the next edge.
- R9: irq_ret_i without irq_take_i copies status bit 1 into status bit 0 at the next edge.
- R10: sat_i sets status bit 9. The bit stays set until a status write carries 0 in bit 9 without sat_i in the same cycle.
- R11: Entry and return events override bits 0 and 1 of a status write made in the same cycle, and entry wins over return.
- R12: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | DATA_W | Read data, combinational |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | DATA_W | Write data |
| pc_e1_i | input | DATA_W | Execution-phase program counter |
| irq_pin_i | input | NUM_IRQ | Maskable interrupt pins |
| irq_take_i | input | 1 | Interrupt entry event |
| irq_take_id_i | input | ID_W | Number of the interrupt being taken |
| irq_ret_i | input | 1 | Return-from-interrupt event |
| sat_i | input | 1 | Saturation event |
| amr_o | output | DATA_W | Addressing mode register |
| csr_o | output | DATA_W | Control/status register |
| ier_o | output | DATA_W | Interrupt enable register |
| ifr_o | output | DATA_W | Interrupt flags |
| istp_o | output | DATA_W | Service table pointer |
| irp_o | output | DATA_W | Interrupt return pointer |
| nrp_o | output | DATA_W | Nonmaskable return pointer |
| fadd_cfg_o | output | DATA_W | Adder configuration |
| faux_cfg_o | output | DATA_W | Auxiliary configuration |
| fmul_cfg_o | output | DATA_W | Multiplier configuration |

## Verification
Read data depends only on the address and the current state, so it is due in the same cycle as rd_addr_i and pc_e1_i. Writes, pin events, entry, return and saturation all appear exactly one edge later. The bench drives every input on the falling edge and advances its reference model at the rising edge. It compares all outputs shortly after the next falling edge, and the read address sweeps one address per cycle, so every address is compared against the model again and again. The directed cases put conflicting events in the same cycle, so that the priority rules are checked on the edge where they apply.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  typedef logic [4:0] creg_addr_t;

  localparam creg_addr_t A_AMR  = 5'h00;
  localparam creg_addr_t A_CSR  = 5'h01;
  localparam creg_addr_t A_FLAG = 5'h02;  // read: flags, write: set
  localparam creg_addr_t A_CLR  = 5'h03;  // write-only clear
  localparam creg_addr_t A_IER  = 5'h04;
  localparam creg_addr_t A_ISTP = 5'h05;
  localparam creg_addr_t A_IRP  = 5'h06;
  localparam creg_addr_t A_NRP  = 5'h07;
  localparam creg_addr_t A_PC   = 5'h10;
  localparam creg_addr_t A_FADD = 5'h12;
  localparam creg_addr_t A_FAUX = 5'h13;
  localparam creg_addr_t A_FMUL = 5'h14;

  localparam int unsigned GIE_BIT  = 0;
  localparam int unsigned PGIE_BIT = 1;
  localparam int unsigned SAT_BIT  = 9;

  localparam int unsigned NUM_PLAIN = 8;
  localparam int unsigned P_AMR  = 0;
  localparam int unsigned P_IER  = 1;
  localparam int unsigned P_ISTP = 2;
  localparam int unsigned P_IRP  = 3;
  localparam int unsigned P_NRP  = 4;
  localparam int unsigned P_FADD = 5;
  localparam int unsigned P_FAUX = 6;
  localparam int unsigned P_FMUL = 7;

  localparam creg_addr_t PLAIN_ADDR [NUM_PLAIN] = '{
    A_AMR, A_IER, A_ISTP, A_IRP, A_NRP, A_FADD, A_FAUX, A_FMUL
  };
endpackage

// File: rtl/ctl_plain_regs.sv
module ctl_plain_regs
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM    = NUM_PLAIN
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  creg_addr_t                 wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM-1:0][DATA_W-1:0] q_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q_o[g] <= '0;
      else if (wr_en_i && wr_addr_i == PLAIN_ADDR[g]) q_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ctl_irq_flags.sv
module ctl_irq_flags #(
  parameter int unsigned NUM_IRQ = 16,
  parameter int unsigned ID_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pin_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  input  logic               take_i,
  input  logic [ID_W-1:0]    take_id_i,
  output logic [NUM_IRQ-1:0] flags_o
);
  logic [NUM_IRQ-1:0] take_mask;
  logic [NUM_IRQ-1:0] clr_mask;
  logic [NUM_IRQ-1:0] set_mask;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) take_mask[i] = take_i && (take_id_i == ID_W'(i));
  end

  assign clr_mask = sw_clr_i | take_mask;
  assign set_mask = pin_i | sw_set_i;

  // set after clear: hardware and software sets win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/ctl_status.sv
module ctl_status
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  input  logic              ret_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] csr_o
);
  logic [DATA_W-1:0] csr_nxt;

  always_comb begin
    csr_nxt = csr_o;
    if (wr_i) csr_nxt = wr_data_i;
    if (take_i) begin
      csr_nxt[PGIE_BIT] = csr_o[GIE_BIT];
      csr_nxt[GIE_BIT]  = 1'b0;
    end else if (ret_i) begin
      csr_nxt[GIE_BIT]  = csr_o[PGIE_BIT];
    end
    if (sat_i) csr_nxt[SAT_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_o <= '0;
    else         csr_o <= csr_nxt;
  end
endmodule

// File: rtl/ctl_rd_mux.sv
module ctl_rd_mux
  import ctl_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM    = NUM_PLAIN
) (
  input  creg_addr_t                 rd_addr_i,
  input  logic [NUM-1:0][DATA_W-1:0] plain_i,
  input  logic [DATA_W-1:0]          csr_i,
  input  logic [DATA_W-1:0]          ifr_i,
  input  logic [DATA_W-1:0]          pc_i,
  output logic [DATA_W-1:0]          rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CSR:   rd_data_o = csr_i;
      A_FLAG:  rd_data_o = ifr_i;
      A_PC:    rd_data_o = pc_i;
      default: begin
        for (int i = 0; i < NUM; i++)
          if (rd_addr_i == PLAIN_ADDR[i]) rd_data_o = plain_i[i];
      end
    endcase
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned NUM_IRQ = 16,
  localparam int unsigned ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4:0]         rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [4:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0]  pc_e1_i,
  input  logic [NUM_IRQ-1:0] irq_pin_i,
  input  logic               irq_take_i,
  input  logic [ID_W-1:0]    irq_take_id_i,
  input  logic               irq_ret_i,
  input  logic               sat_i,
  output logic [DATA_W-1:0]  amr_o,
  output logic [DATA_W-1:0]  csr_o,
  output logic [DATA_W-1:0]  ier_o,
  output logic [DATA_W-1:0]  ifr_o,
  output logic [DATA_W-1:0]  istp_o,
  output logic [DATA_W-1:0]  irp_o,
  output logic [DATA_W-1:0]  nrp_o,
  output logic [DATA_W-1:0]  fadd_cfg_o,
  output logic [DATA_W-1:0]  faux_cfg_o,
  output logic [DATA_W-1:0]  fmul_cfg_o
);
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [NUM_IRQ-1:0]               flags;
  logic [NUM_IRQ-1:0]               sw_set;
  logic [NUM_IRQ-1:0]               sw_clr;
  logic                             wr_csr;

  assign wr_csr = wr_en_i && (wr_addr_i == A_CSR);
  assign sw_set = (wr_en_i && wr_addr_i == A_FLAG) ? wr_data_i[NUM_IRQ-1:0] : '0;
  assign sw_clr = (wr_en_i && wr_addr_i == A_CLR)  ? wr_data_i[NUM_IRQ-1:0] : '0;

  ctl_plain_regs #(.DATA_W(DATA_W), .NUM(NUM_PLAIN)) u_plain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .q_o      (plain_q)
  );

  ctl_irq_flags #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (irq_pin_i),
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .take_i   (irq_take_i),
    .take_id_i(irq_take_id_i),
    .flags_o  (flags)
  );

  ctl_status #(.DATA_W(DATA_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_csr),
    .wr_data_i(wr_data_i),
    .take_i   (irq_take_i),
    .ret_i    (irq_ret_i),
    .sat_i    (sat_i),
    .csr_o    (csr_o)
  );

  assign ifr_o = DATA_W'(flags);

  ctl_rd_mux #(.DATA_W(DATA_W), .NUM(NUM_PLAIN)) u_rd (
    .rd_addr_i(rd_addr_i),
    .plain_i  (plain_q),
    .csr_i    (csr_o),
    .ifr_i    (ifr_o),
    .pc_i     (pc_e1_i),
    .rd_data_o(rd_data_o)
  );

  assign amr_o      = plain_q[P_AMR];
  assign ier_o      = plain_q[P_IER];
  assign istp_o     = plain_q[P_ISTP];
  assign irp_o      = plain_q[P_IRP];
  assign nrp_o      = plain_q[P_NRP];
  assign fadd_cfg_o = plain_q[P_FADD];
  assign faux_cfg_o = plain_q[P_FAUX];
  assign fmul_cfg_o = plain_q[P_FMUL];
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk #(
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned NUM_IRQ = 16,
  localparam int unsigned ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [4:0]         rd_addr_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               wr_en_i,
  input logic [4:0]         wr_addr_i,
  input logic [DATA_W-1:0]  pc_e1_i,
  input logic [NUM_IRQ-1:0] irq_pin_i,
  input logic               irq_take_i,
  input logic               irq_ret_i,
  input logic               sat_i,
  input logic [DATA_W-1:0]  csr_o,
  input logic [DATA_W-1:0]  ifr_o
);
  logic ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= 1'b1;
  end

  assert_pin_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> ((ifr_o[NUM_IRQ-1:0] & $past(irq_pin_i)) == $past(irq_pin_i)));

  assert_take_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && $past(irq_take_i)) |-> (!csr_o[0] && csr_o[1] == $past(csr_o[0])));

  assert_ret_gie_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && $past(irq_ret_i) && !$past(irq_take_i)) |-> (csr_o[0] == $past(csr_o[1])));

  assert_sat_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && $past(sat_i)) |-> csr_o[9]);

  assert_sat_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && $past(csr_o[9]) && !($past(wr_en_i) && $past(wr_addr_i) == 5'h01)) |-> csr_o[9]);

  assert_clr_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 5'h03) |-> (rd_data_o == '0));

  assert_pc_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 5'h10) |-> (rd_data_o == pc_e1_i));
endmodule

bind ctl_regbank ctl_regbank_chk #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .pc_e1_i   (pc_e1_i),
  .irq_pin_i (irq_pin_i),
  .irq_take_i(irq_take_i),
  .irq_ret_i (irq_ret_i),
  .sat_i     (sat_i),
  .csr_o     (csr_o),
  .ifr_o     (ifr_o)
);

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
  localparam int DW = 32;
  localparam int NI = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          wr_en_i = 1'b0;
  logic [4:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] pc_e1_i = '0;
  logic [NI-1:0] irq_pin_i = '0;
  logic          irq_take_i = 1'b0;
  logic [3:0]    irq_take_id_i = '0;
  logic          irq_ret_i = 1'b0;
  logic          sat_i = 1'b0;
  logic [DW-1:0] amr_o, csr_o, ier_o, ifr_o, istp_o, irp_o, nrp_o;
  logic [DW-1:0] fadd_cfg_o, faux_cfg_o, fmul_cfg_o;

  ctl_regbank #(.DATA_W(DW), .NUM_IRQ(NI)) uut (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] m_reg [32];
  logic [31:0] m_csr = '0;
  logic [31:0] m_ifr = '0;

  function automatic bit is_plain(logic [4:0] a);
    return a inside {5'h00, 5'h04, 5'h05, 5'h06, 5'h07, 5'h12, 5'h13, 5'h14};
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    if (a == 5'h01) return m_csr;
    if (a == 5'h02) return m_ifr;
    if (a == 5'h10) return pc_e1_i;
    if (is_plain(a)) return m_reg[a];
    return '0;
  endfunction

  function automatic string rd_tag(logic [4:0] a);
    if (a == 5'h02) return "R2";
    if (a == 5'h03) return "R3";
    if (a == 5'h10) return "R4";
    if (a == 5'h01 || is_plain(a)) return "R1";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(rd_tag(rd_addr_i), $sformatf("read @%h", rd_addr_i), rd_data_o, m_read(rd_addr_i));
    chk("R8", "status", csr_o, m_csr);
    chk("R6", "flags", ifr_o, m_ifr);
    chk("R1", "mode", amr_o, m_reg[5'h00]);
    chk("R1", "enable", ier_o, m_reg[5'h04]);
    chk("R1", "table ptr", istp_o, m_reg[5'h05]);
    chk("R1", "ret ptr", irp_o, m_reg[5'h06]);
    chk("R1", "nmi ptr", nrp_o, m_reg[5'h07]);
    chk("R1", "fadd", fadd_cfg_o, m_reg[5'h12]);
    chk("R1", "faux", faux_cfg_o, m_reg[5'h13]);
    chk("R1", "fmul", fmul_cfg_o, m_reg[5'h14]);
  endtask

  // model advance at the edge, compare after the following falling edge
  task automatic tick();
    logic [31:0] n_csr, n_ifr, clr, set;
    logic [31:0] n_reg [32];
    n_reg = m_reg;
    if (wr_en_i && is_plain(wr_addr_i)) n_reg[wr_addr_i] = wr_data_i;
    n_csr = m_csr;
    if (wr_en_i && wr_addr_i == 5'h01) n_csr = wr_data_i;
    if (irq_take_i) begin
      n_csr[1] = m_csr[0];
      n_csr[0] = 1'b0;
    end else if (irq_ret_i) n_csr[0] = m_csr[1];
    if (sat_i) n_csr[9] = 1'b1;
    clr = 0;
    set = 32'(irq_pin_i);
    if (wr_en_i && wr_addr_i == 5'h03) clr |= wr_data_i;
    if (wr_en_i && wr_addr_i == 5'h02) set |= wr_data_i;
    if (irq_take_i) clr |= 32'(1) << irq_take_id_i;
    n_ifr = ((m_ifr & ~clr) | set) & 32'h0000_FFFF;
    @(posedge clk_i);
    m_reg = n_reg;
    m_csr = n_csr;
    m_ifr = n_ifr;
    @(negedge clk_i);
    cyc++;
    rd_addr_i = 5'(cyc);
    pc_e1_i = 32'h1000 + 32'(cyc) * 4;
    #1;
    compare_all();
    wr_en_i = 0; irq_pin_i = 0; irq_take_i = 0; irq_ret_i = 0; sat_i = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    #20 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R12 reset state
    chk("R12", "status after reset", csr_o, 0);
    chk("R12", "flags after reset", ifr_o, 0);
    chk("R12", "mode after reset", amr_o, 0);
    idle(32);
    // R1 writes to every writable address
    wr(5'h00, 32'hA0A0_0001); tick();
    wr(5'h04, 32'h0000_FFF3); tick();
    wr(5'h05, 32'h8000_0400); tick();
    wr(5'h06, 32'h1234_5678); tick();
    wr(5'h07, 32'hCAFE_0000); tick();
    wr(5'h12, 32'h0000_0012); tick();
    wr(5'h13, 32'h0000_0013); tick();
    wr(5'h14, 32'h0000_0014); tick();
    wr(5'h01, 32'h0000_0001); tick();
    // R4 R5 writes with no effect
    wr(5'h10, 32'hFFFF_FFFF); tick();
    wr(5'h08, 32'hFFFF_FFFF); tick();
    wr(5'h1F, 32'hFFFF_FFFF); tick();
    wr(5'h0B, 32'hFFFF_FFFF); tick();
    idle(32);
    // R2 set through write, R3 clear through write
    wr(5'h02, 32'hFFFF_00F0); tick();
    wr(5'h03, 32'h0000_0030); tick();
    // R6 pins
    irq_pin_i = 16'h0101; tick();
    // R7 pin beats same-cycle software clear
    irq_pin_i = 16'h0004; wr(5'h03, 32'h0000_0044); tick();
    // R8 entry, then R9 return
    irq_take_i = 1; irq_take_id_i = 4'd7; tick();
    irq_ret_i = 1; tick();
    // R7 pin beats entry clear
    irq_take_i = 1; irq_take_id_i = 4'd0; irq_pin_i = 16'h0001; tick();
    irq_ret_i = 1; tick();
    // R11 entry overrides status write; entry wins over return
    wr(5'h01, 32'h0000_0000); irq_take_i = 1; irq_take_id_i = 4'd2; tick();
    irq_ret_i = 1; wr(5'h01, 32'h0000_0002); tick();
    irq_take_i = 1; irq_ret_i = 1; tick();
    // R10 sticky saturation
    sat_i = 1; tick();
    idle(5);
    sat_i = 1; wr(5'h01, 32'h0000_0000); tick();
    idle(3);
    wr(5'h01, 32'h0000_0000); tick();
    idle(32);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      a = 5'($urandom_range(0, 31));
      if (($urandom & 3) != 0) a = 5'($urandom_range(0, 7));
      if (($urandom & 1) != 0) wr(a, $urandom);
      irq_pin_i = (($urandom & 7) == 0) ? 16'($urandom) : '0;
      irq_take_i = (($urandom & 7) == 0);
      irq_take_id_i = 4'($urandom);
      irq_ret_i = (($urandom & 7) == 0);
      sat_i = (($urandom & 15) == 0);
      tick();
    end
    idle(32);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule